// File: doc/BRIEF.md
# Physical Register Reclaim Pool with Early Release

This block owns the free and busy state of every physical register in an out-of-order core and decides when each register may be handed out again. Rename asks for up to four registers per cycle. The block grants them from the lowest-numbered available registers, or raises a stall when it cannot grant the whole request.

A busy register goes back to the pool only when four things are true: its value has been produced, no map entry names it any more, no reader is still waiting to read it, and no saved map checkpoint still refers to it. The producing value can leave the map early. When writeback finds that the result is narrow enough to sit inside the map entry itself, that writeback both completes and unmaps the register. The later release sent when the next writer of the same logical register commits then has nothing left to do, and it must not disturb the pool.

Events that arrive in a cycle are merged into a register's state before allocation looks at the pool. A register whose last holding condition clears in a cycle can therefore be granted in that same cycle.

Top module: `prf_release_pool`

## Requirements
- R1: After reset, registers 0 to ARCH_REGS-1 (16 by default) are busy, complete and still mapped, with no readers and no checkpoint references. Every higher-numbered register of the 32 is free, so the first request for four after reset receives 16, 17, 18 and 19.
- R2: When `allocReq` is n (1 to 4) and at least n registers are available, `allocGrant` is 1 and slots 0 to n-1 of `allocTags` carry the n lowest-numbered available registers in ascending order. Slot k occupies bits [k*5 +: 5], and unused slots read 0.
- R3: When `allocReq` is greater than the number of available registers, or greater than 4, `allocStall` is 1, `allocGrant` is 0 and no register is consumed. When `allocReq` is 0, both outputs are 0.
- R4: A busy register becomes available only when it is complete, unmapped, has a reader count of zero and has a checkpoint count of zero.
- R5: A plain writeback (`wbNarrow`=0) marks the register complete. A commit release marks it unmapped. A narrow writeback (`wbNarrow`=1) marks it both complete and unmapped. The flags can be set in either order.
- R6: Each reader add increments the register's outstanding-reader count and each reader done decrements it. The register stays held while the count is above zero, including when several readers are outstanding.
- R7: Each checkpoint add increments the register's checkpoint reference count and each checkpoint drop decrements it. The register stays held while the count is above zero.
- R8: A release or writeback aimed at a register that is already free has no effect. The register is counted once in the pool and is granted once.
- R9: Events presented in a cycle are applied before that cycle's allocation. A register whose last condition clears in that cycle can be granted in the same cycle.
- R10: A register that is granted starts a new lifetime with its completion and unmapped flags clear, so it needs a fresh writeback and a fresh release before it can be reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 3 | Number of registers requested this cycle (0 to 4) |
| allocGrant | output | 1 | Whole request granted this cycle |
| allocTags | output | 20 | Granted register numbers, slot k at bits [k*5 +: 5] |
| allocStall | output | 1 | Request cannot be granted this cycle |
| wbValid | input | 1 | Writeback result for `wbTag` |
| wbNarrow | input | 1 | Writeback value was inlined into the map (early release) |
| wbTag | input | 5 | Register written back |
| commitRelValid | input | 1 | Next writer committed, releasing `commitRelTag` |
| commitRelTag | input | 5 | Register released at commit |
| readAddValid | input | 1 | New reader of `readAddTag` entered the window |
| readAddTag | input | 5 | Register gaining a reader |
| readDoneValid | input | 1 | A reader of `readDoneTag` has read it |
| readDoneTag | input | 5 | Register losing a reader |
| ckptAddValid | input | 1 | A map checkpoint captured `ckptAddTag` |
| ckptAddTag | input | 5 | Register gaining a checkpoint reference |
| ckptDropValid | input | 1 | A checkpoint naming `ckptDropTag` was discarded |
| ckptDropTag | input | 5 | Register losing a checkpoint reference |

## Verification
Allocation is first tried with requests of one, two and four against pools of different sizes. These cases separate lowest-first ordering, all-or-nothing stalling and the out-of-range request from one another. Each holding condition is then cleared last on its own: completion, unmapping, the final reader and the final checkpoint. Each of these cases shows whether that condition alone gates reuse, and whether the register comes back in the very cycle it clears. Narrow writebacks followed by a stray commit release, and by reallocation of the same register, tell a harmless duplicate apart from one that changes the pool or leaks stale flags into the next lifetime.

// File: rtl/prf_pool_pkg.sv
package prf_pool_pkg;

  // Pool geometry shared by every module of the block.
  localparam int unsigned PREG_NUM  = 32;
  localparam int unsigned ALLOC_MAX = 4;
  localparam int unsigned TAG_W     = $clog2(PREG_NUM);
  localparam int unsigned REQ_W     = $clog2(ALLOC_MAX + 1);
  localparam int unsigned CNT_W     = $clog2(PREG_NUM + 1);

  typedef logic [TAG_W-1:0] pregTag_t;

  // Strobes sent from allocation control to the state datapath.
  typedef struct packed {
    logic                fire;
    logic [PREG_NUM-1:0] grantMask;
  } grantStrobe_t;

endpackage

// File: rtl/prf_pool_state.sv
module prf_pool_state
  import prf_pool_pkg::*;
#(
  parameter int unsigned ARCH_REGS = 16,
  parameter int unsigned READ_W    = 4,
  parameter int unsigned CKPT_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wbValid,
  input  logic                wbNarrow,
  input  pregTag_t            wbTag,
  input  logic                commitRelValid,
  input  pregTag_t            commitRelTag,
  input  logic                readAddValid,
  input  pregTag_t            readAddTag,
  input  logic                readDoneValid,
  input  pregTag_t            readDoneTag,
  input  logic                ckptAddValid,
  input  pregTag_t            ckptAddTag,
  input  logic                ckptDropValid,
  input  pregTag_t            ckptDropTag,
  input  grantStrobe_t        strobe,
  output logic [PREG_NUM-1:0] availVec
);

  for (genvar gi = 0; gi < PREG_NUM; gi++) begin : g_reg
    localparam pregTag_t MY_TAG   = pregTag_t'(gi);
    localparam logic     IS_ARCH  = (gi < ARCH_REGS);

    logic              freeQ, completeQ, unmappedQ;
    logic [READ_W-1:0] readQ, readNext;
    logic [CKPT_W-1:0] ckptQ, ckptNext;
    logic              completeNext, unmappedNext;
    logic              wbHit, relHit, rdAddHit, rdDoneHit, ckAddHit, ckDropHit;
    logic              releaseNow, granted;

    assign wbHit     = wbValid        && (wbTag        == MY_TAG);
    assign relHit    = commitRelValid && (commitRelTag == MY_TAG);
    assign rdAddHit  = readAddValid   && (readAddTag   == MY_TAG);
    assign rdDoneHit = readDoneValid  && (readDoneTag  == MY_TAG);
    assign ckAddHit  = ckptAddValid   && (ckptAddTag   == MY_TAG);
    assign ckDropHit = ckptDropValid  && (ckptDropTag  == MY_TAG);

    // Merge this cycle's events before judging reuse.
    always_comb begin
      completeNext = completeQ | wbHit;
      unmappedNext = unmappedQ | relHit | (wbHit & wbNarrow);
      readNext     = readQ + {{(READ_W-1){1'b0}}, rdAddHit}
                           - {{(READ_W-1){1'b0}}, rdDoneHit};
      ckptNext     = ckptQ + {{(CKPT_W-1){1'b0}}, ckAddHit}
                           - {{(CKPT_W-1){1'b0}}, ckDropHit};
    end

    assign releaseNow = !freeQ && completeNext && unmappedNext &&
                        (readNext == '0) && (ckptNext == '0);
    assign availVec[gi] = freeQ | releaseNow;
    assign granted      = strobe.fire && strobe.grantMask[gi];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        freeQ     <= !IS_ARCH;
        completeQ <= IS_ARCH;
        unmappedQ <= 1'b0;
        readQ     <= '0;
        ckptQ     <= '0;
      end else if (granted) begin
        freeQ     <= 1'b0;
        completeQ <= 1'b0;
        unmappedQ <= 1'b0;
        readQ     <= '0;
        ckptQ     <= '0;
      end else if (availVec[gi]) begin
        // Free (or freeing now): later events on it are ignored.
        freeQ     <= 1'b1;
        completeQ <= 1'b0;
        unmappedQ <= 1'b0;
        readQ     <= '0;
        ckptQ     <= '0;
      end else begin
        completeQ <= completeNext;
        unmappedQ <= unmappedNext;
        readQ     <= readNext;
        ckptQ     <= ckptNext;
      end
    end

    // R10: a fresh grant leaves the register busy with clear flags.
    p_grant_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
      granted |=> (!freeQ && !completeQ && !unmappedQ));

    // R8: a free register stays free until it is granted.
    p_dup_release_r8: assert property (@(posedge clk) disable iff (!rstN)
      (freeQ && !granted) |=> freeQ);

    // R4: nothing holds a register that sits in the pool.
    p_free_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
      freeQ |-> ((readQ == '0) && (ckptQ == '0)));
  end

endmodule

// File: rtl/prf_pool_alloc.sv
module prf_pool_alloc
  import prf_pool_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [REQ_W-1:0]             allocReq,
  input  logic [PREG_NUM-1:0]          availVec,
  output grantStrobe_t                 strobe,
  output logic                         allocGrant,
  output logic [ALLOC_MAX*TAG_W-1:0]   allocTags,
  output logic                         allocStall
);

  pregTag_t            slotTag [ALLOC_MAX];
  logic [CNT_W-1:0]    availCount;
  logic [PREG_NUM-1:0] remain;
  logic                found;
  logic                tooMany;

  // Population count of the available pool.
  always_comb begin
    availCount = '0;
    for (int i = 0; i < PREG_NUM; i++) begin
      availCount = availCount + CNT_W'(availVec[i]);
    end
  end

  // Pick the lowest available registers, one per slot.
  always_comb begin
    remain = availVec;
    for (int k = 0; k < ALLOC_MAX; k++) begin
      slotTag[k] = '0;
      found      = 1'b0;
      for (int i = 0; i < PREG_NUM; i++) begin
        if (!found && remain[i]) begin
          slotTag[k] = pregTag_t'(i);
          found      = 1'b1;
        end
      end
      if (found) remain[slotTag[k]] = 1'b0;
    end
  end

  assign tooMany    = (allocReq > REQ_W'(ALLOC_MAX)) ||
                      (CNT_W'(allocReq) > availCount);
  assign allocStall = (allocReq != '0) && tooMany;
  assign allocGrant = (allocReq != '0) && !tooMany;

  always_comb begin
    strobe.fire      = allocGrant;
    strobe.grantMask = '0;
    allocTags        = '0;
    for (int k = 0; k < ALLOC_MAX; k++) begin
      if (allocGrant && (REQ_W'(k) < allocReq)) begin
        strobe.grantMask[slotTag[k]]     = 1'b1;
        allocTags[k*TAG_W +: TAG_W]      = slotTag[k];
      end
    end
  end

  // R3: stall and grant never coincide.
  p_stall_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    allocStall |-> !allocGrant);

  // R2: a grant consumes exactly the requested number of registers.
  p_grant_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> ($countones(strobe.grantMask) == int'(allocReq)));

  // R2: every consumed register came from the available pool.
  p_grant_in_pool_r2: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> ((strobe.grantMask & ~availVec) == '0));

endmodule

// File: rtl/prf_release_pool.sv
module prf_release_pool
  import prf_pool_pkg::*;
#(
  parameter int unsigned ARCH_REGS = 16,
  parameter int unsigned READ_W    = 4,
  parameter int unsigned CKPT_W    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [REQ_W-1:0]           allocReq,
  output logic                       allocGrant,
  output logic [ALLOC_MAX*TAG_W-1:0] allocTags,
  output logic                       allocStall,
  input  logic                       wbValid,
  input  logic                       wbNarrow,
  input  logic [TAG_W-1:0]           wbTag,
  input  logic                       commitRelValid,
  input  logic [TAG_W-1:0]           commitRelTag,
  input  logic                       readAddValid,
  input  logic [TAG_W-1:0]           readAddTag,
  input  logic                       readDoneValid,
  input  logic [TAG_W-1:0]           readDoneTag,
  input  logic                       ckptAddValid,
  input  logic [TAG_W-1:0]           ckptAddTag,
  input  logic                       ckptDropValid,
  input  logic [TAG_W-1:0]           ckptDropTag
);

  grantStrobe_t        strobe;
  logic [PREG_NUM-1:0] availVec;

  prf_pool_state #(
    .ARCH_REGS(ARCH_REGS),
    .READ_W   (READ_W),
    .CKPT_W   (CKPT_W)
  ) i_state (
    .clk           (clk),
    .rstN          (rstN),
    .wbValid       (wbValid),
    .wbNarrow      (wbNarrow),
    .wbTag         (wbTag),
    .commitRelValid(commitRelValid),
    .commitRelTag  (commitRelTag),
    .readAddValid  (readAddValid),
    .readAddTag    (readAddTag),
    .readDoneValid (readDoneValid),
    .readDoneTag   (readDoneTag),
    .ckptAddValid  (ckptAddValid),
    .ckptAddTag    (ckptAddTag),
    .ckptDropValid (ckptDropValid),
    .ckptDropTag   (ckptDropTag),
    .strobe        (strobe),
    .availVec      (availVec)
  );

  prf_pool_alloc i_alloc (
    .clk       (clk),
    .rstN      (rstN),
    .allocReq  (allocReq),
    .availVec  (availVec),
    .strobe    (strobe),
    .allocGrant(allocGrant),
    .allocTags (allocTags),
    .allocStall(allocStall)
  );

endmodule

// File: tb/test_prf_release_pool.sv
module test_prf_release_pool;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  allocReq;
  logic        allocGrant, allocStall;
  logic [19:0] allocTags;
  logic        wbValid, wbNarrow, commitRelValid, readAddValid, readDoneValid;
  logic        ckptAddValid, ckptDropValid;
  logic [4:0]  wbTag, commitRelTag, readAddTag, readDoneTag, ckptAddTag, ckptDropTag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prf_release_pool i_prf_release_pool (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocGrant(allocGrant),
    .allocTags(allocTags), .allocStall(allocStall),
    .wbValid(wbValid), .wbNarrow(wbNarrow), .wbTag(wbTag),
    .commitRelValid(commitRelValid), .commitRelTag(commitRelTag),
    .readAddValid(readAddValid), .readAddTag(readAddTag),
    .readDoneValid(readDoneValid), .readDoneTag(readDoneTag),
    .ckptAddValid(ckptAddValid), .ckptAddTag(ckptAddTag),
    .ckptDropValid(ckptDropValid), .ckptDropTag(ckptDropTag)
  );

  // Event kinds: 0 none, 1 wb, 2 narrow wb, 3 commit release,
  // 4 reader add, 5 reader done, 6 ckpt add, 7 ckpt drop.
  typedef struct packed {
    logic [3:0] rq;
    logic [2:0] req;
    logic [2:0] k1; logic [4:0] t1;
    logic [2:0] k2; logic [4:0] t2;
    logic       g;  logic       s;
    logic [4:0] e0; logic [4:0] e1; logic [4:0] e2; logic [4:0] e3;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1, 4, 0, 0, 0, 0, 1, 0, 16, 17, 18, 19},  // R1 first grant
    '{5, 0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0},      // R5 commit frees arch p3
    '{2, 1, 0, 0, 0, 0, 1, 0, 3, 0, 0, 0},      // R2 lowest first
    '{6, 1, 3, 5, 4, 5, 1, 0, 20, 0, 0, 0},     // R6 reader holds p5
    '{2, 4, 0, 0, 0, 0, 1, 0, 21, 22, 23, 24},  // R2
    '{2, 4, 0, 0, 0, 0, 1, 0, 25, 26, 27, 28},  // R2
    '{3, 4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0},      // R3 only three left
    '{9, 4, 5, 5, 0, 0, 1, 0, 5, 29, 30, 31},   // R9 last reader, same cycle
    '{3, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0},      // R3 empty pool
    '{7, 1, 6, 6, 3, 6, 0, 1, 0, 0, 0, 0},      // R7 ckpt holds p6
    '{7, 1, 7, 6, 0, 0, 1, 0, 6, 0, 0, 0},      // R7 drop frees, same cycle
    '{5, 0, 2, 16, 0, 0, 0, 0, 0, 0, 0, 0},     // R5 narrow wb early release
    '{8, 0, 3, 16, 0, 0, 0, 0, 0, 0, 0, 0},     // R8 duplicate release
    '{8, 2, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0},      // R8 still one free
    '{8, 1, 0, 0, 0, 0, 1, 0, 16, 0, 0, 0},     // R8 granted once
    '{5, 1, 1, 17, 0, 0, 0, 1, 0, 0, 0, 0},     // R5 complete but mapped
    '{5, 1, 3, 17, 0, 0, 1, 0, 17, 0, 0, 0},    // R5 release completes it
    '{4, 1, 3, 18, 0, 0, 0, 1, 0, 0, 0, 0},     // R4 unmapped, not complete
    '{4, 1, 1, 18, 0, 0, 1, 0, 18, 0, 0, 0},    // R4 wb last
    '{6, 0, 4, 19, 0, 0, 0, 0, 0, 0, 0, 0},     // R6 reader one
    '{6, 0, 4, 19, 0, 0, 0, 0, 0, 0, 0, 0},     // R6 reader two
    '{6, 1, 2, 19, 0, 0, 0, 1, 0, 0, 0, 0},     // R6 two readers hold
    '{6, 1, 5, 19, 0, 0, 0, 1, 0, 0, 0, 0},     // R6 one reader holds
    '{6, 1, 5, 19, 0, 0, 1, 0, 19, 0, 0, 0},    // R6 last reader frees
    '{7, 0, 6, 20, 0, 0, 0, 0, 0, 0, 0, 0},     // R7 ref one
    '{7, 0, 6, 20, 0, 0, 0, 0, 0, 0, 0, 0},     // R7 ref two
    '{7, 1, 2, 20, 7, 20, 0, 1, 0, 0, 0, 0},    // R7 one ref left
    '{7, 1, 7, 20, 0, 0, 1, 0, 20, 0, 0, 0},    // R7 last ref frees
    '{10, 1, 1, 16, 0, 0, 0, 1, 0, 0, 0, 0},    // R10 fresh p16 still mapped
    '{10, 1, 3, 16, 0, 0, 1, 0, 16, 0, 0, 0},   // R10 needs own release
    '{3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},      // R3 idle request
    '{4, 2, 2, 21, 3, 22, 0, 1, 0, 0, 0, 0},    // R4 p22 incomplete
    '{2, 2, 1, 22, 0, 0, 1, 0, 21, 22, 0, 0}    // R2 two granted
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic clearIn();
    allocReq = 0; wbValid = 0; wbNarrow = 0; wbTag = 0;
    commitRelValid = 0; commitRelTag = 0; readAddValid = 0; readAddTag = 0;
    readDoneValid = 0; readDoneTag = 0; ckptAddValid = 0; ckptAddTag = 0;
    ckptDropValid = 0; ckptDropTag = 0;
  endtask

  task automatic applyEv(input logic [2:0] kind, input logic [4:0] tag);
    case (kind)
      3'd1: begin wbValid = 1; wbNarrow = 0; wbTag = tag; end
      3'd2: begin wbValid = 1; wbNarrow = 1; wbTag = tag; end
      3'd3: begin commitRelValid = 1; commitRelTag = tag; end
      3'd4: begin readAddValid = 1; readAddTag = tag; end
      3'd5: begin readDoneValid = 1; readDoneTag = tag; end
      3'd6: begin ckptAddValid = 1; ckptAddTag = tag; end
      3'd7: begin ckptDropValid = 1; ckptDropTag = tag; end
      default: ;
    endcase
  endtask

  task automatic doReset();
    @(negedge clk);
    clearIn();
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  // Watchdog: a hung run counts as a failure.
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    clearIn();
    doReset();

    // R1: reset state, nothing requested.
    #2;
    chk("R1", "grant idle", 32'(allocGrant), 0);
    chk("R1", "stall idle", 32'(allocStall), 0);

    for (int v = 0; v < NV; v++) begin
      string tagStr;
      @(negedge clk);
      clearIn();
      allocReq = VEC[v].req;
      applyEv(VEC[v].k1, VEC[v].t1);
      applyEv(VEC[v].k2, VEC[v].t2);
      #2;
      tagStr = $sformatf("R%0d row %0d", VEC[v].rq, v);
      chk(tagStr, "grant", 32'(allocGrant), 32'(VEC[v].g));
      chk(tagStr, "stall", 32'(allocStall), 32'(VEC[v].s));
      if (VEC[v].g) begin
        chk(tagStr, "tags", 32'(allocTags),
            32'({VEC[v].e3, VEC[v].e2, VEC[v].e1, VEC[v].e0}));
      end
    end

    // R1: reset in mid-run restores the initial pool.
    doReset();
    @(negedge clk);
    clearIn();
    allocReq = 5;  // R3: above the per-cycle limit
    #2;
    chk("R3", "over-limit stall", 32'(allocStall), 1);
    chk("R3", "over-limit grant", 32'(allocGrant), 0);

    @(negedge clk);
    clearIn();
    allocReq = 4;
    #2;
    chk("R1", "post-reset grant", 32'(allocGrant), 1);
    chk("R1", "post-reset tags", 32'(allocTags), 32'({5'd19, 5'd18, 5'd17, 5'd16}));

    // R5/R9: arch register p0 released at commit, granted same cycle.
    @(negedge clk);
    clearIn();
    allocReq = 2;
    applyEv(3'd3, 5'd0);
    #2;
    chk("R9", "arch release grant", 32'(allocGrant), 1);
    chk("R9", "arch release tags", 32'(allocTags), 32'({10'd0, 5'd20, 5'd0}));

    @(negedge clk);
    clearIn();
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule